// File: doc/BRIEF.md
# Transmit Descriptor Status Word

This block keeps the 16-bit status and control word of a single transmit descriptor in a packet DMA engine. The host programs the word with the number of bytes to send. That write also hands the descriptor to the hardware by clearing the ownership flag. The transmit engine reports three events back to the block:

- the descriptor's DMA has finished,
- the frame has left the wire,
- the transmit FIFO ran dry partway through the frame.

The block turns those events into the ownership, success and underrun flags. It raises a one-cycle interrupt request for success or for error.

For frames above the long-frame limit, the block asserts a hold output. Hold stays high while the descriptor belongs to the hardware, so the sequencer cannot start the next descriptor until this one's DMA has completed. The reset input is asynchronous and active-low. Inside the block, the release of reset is synchronised to the clock.

Top module: `txd_status_reg`

## Requirements
- R1: After reset the word reads byte count 0, ownership 1, underrun 0 and transmit-OK 0. Hold, irq_ok and irq_err are all 0.
- R2: A host write loads the byte count from write bits 12:0 and clears ownership in the same write. The read word is laid out as: bit 15 transmit-OK, bit 14 underrun, bit 13 ownership, bits 12:0 byte count.
- R3: Write data in bits 15:13 is ignored. A write with those bits at 1 still reads back ownership 0, underrun 0 and transmit-OK 0.
- R4: When a DMA-done event arrives without a host write, ownership is 1 in the following cycle.
- R5: When a transmit-done event arrives with no underrun recorded and none in the same cycle, transmit-OK becomes 1. irq_ok is high for exactly that one cycle.
- R6: An underrun event sets the underrun flag and pulses irq_err for one cycle. A later transmit-done leaves transmit-OK at 0 and produces no irq_ok.
- R7: When an underrun and a transmit-done arrive in the same cycle, the result is underrun 1, transmit-OK 0, and only irq_err pulses.
- R8: A host write clears both the underrun flag and the transmit-OK flag.
- R9: hold_next is 1 exactly when the byte count is greater than 1792 and ownership is 0.
- R10: When a host write and a DMA-done event arrive in the same cycle, the write wins and ownership reads 0.
- R11: Further transmit-done events while transmit-OK is already 1 produce no new irq_ok. irq_ok and irq_err are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data; only bits 12:0 are used |
| host_rdata | output | 16 | Status word read by the host |
| dma_done | input | 1 | DMA for this descriptor finished |
| tx_done | input | 1 | Frame transmission finished |
| fifo_underrun | input | 1 | Transmit FIFO emptied partway through the frame |
| own | output | 1 | Ownership flag (1 = DMA complete, host owns the descriptor) |
| byte_cnt | output | 13 | Programmed byte count |
| hold_next | output | 1 | Blocks the start of the next descriptor |
| irq_ok | output | 1 | One-cycle success interrupt request |
| irq_err | output | 1 | One-cycle error interrupt request |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a host write and the DMA-done event: one clears ownership and the other sets it. The bench drives both in one cycle and expects ownership 0 and hold to follow the new count. The second pair is an underrun and a transmit-done: the bench fires them together and expects only the error flag and the error pulse. A sweep of byte counts across the whole 13-bit range, with extra density around 1792, checks the hold output before and after each DMA completion.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int CNT_W_DEF   = 13;
  localparam int LONG_LIM_DEF = 1792;

  typedef struct packed {
    logic tok;
    logic tun;
    logic own;
  } txd_flags_t;
endpackage

// File: rtl/txd_rst_sync.sv
module txd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/txd_own_cnt.sv
module txd_own_cnt #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             dma_done,
  output logic [CNT_W-1:0] cnt,
  output logic             own
);
  logic [CNT_W-1:0] cnt_d;
  logic             own_d;
  logic             cnt_en, own_en;

  always_comb begin
    cnt_en = wr;
    cnt_d  = wr_cnt;
    own_en = wr | dma_done;
    own_d  = ~wr;              // host write has priority over DMA completion
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      own <= 1'b1;
    end else begin
      if (cnt_en) cnt <= cnt_d;
      if (own_en) own <= own_d;
    end
  end
endmodule

// File: rtl/txd_tx_flags.sv
module txd_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic tx_done,
  input  logic underrun,
  output logic tun,
  output logic tok,
  output logic irq_ok,
  output logic irq_err
);
  logic tun_d, tok_d, irq_ok_d, irq_err_d;

  always_comb begin
    tun_d = tun;
    tok_d = tok;
    if (wr) begin
      tun_d = 1'b0;
      tok_d = 1'b0;
    end else begin
      if (underrun) tun_d = 1'b1;
      if (tx_done && !tun && !underrun) tok_d = 1'b1;
    end
    irq_ok_d  = tok_d & ~tok;
    irq_err_d = tun_d & ~tun;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tun     <= 1'b0;
      tok     <= 1'b0;
      irq_ok  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      tun     <= tun_d;
      tok     <= tok_d;
      irq_ok  <= irq_ok_d;
      irq_err <= irq_err_d;
    end
  end
endmodule

// File: rtl/txd_hold_gen.sv
module txd_hold_gen #(
  parameter int CNT_W    = 13,
  parameter int LONG_LIM = 1792
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             own,
  output logic             hold
);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LONG_LIM);

  always_comb hold = (cnt > LIM_V) && !own;
endmodule

// File: rtl/txd_status_reg.sv
module txd_status_reg #(
  parameter int CNT_W    = txd_pkg::CNT_W_DEF,
  parameter int LONG_LIM = txd_pkg::LONG_LIM_DEF,
  localparam int WORD_W  = CNT_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              dma_done,
  input  logic              tx_done,
  input  logic              fifo_underrun,
  output logic              own,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic              hold_next,
  output logic              irq_ok,
  output logic              irq_err
);
  import txd_pkg::*;

  logic       rst_sync_n;
  logic       tun, tok;
  txd_flags_t flags;

  txd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  txd_own_cnt #(.CNT_W(CNT_W)) u_own (
    .clk(clk), .rst_n(rst_sync_n), .wr(host_wr),
    .wr_cnt(host_wdata[CNT_W-1:0]), .dma_done(dma_done),
    .cnt(byte_cnt), .own(own));

  txd_tx_flags u_flags (
    .clk(clk), .rst_n(rst_sync_n), .wr(host_wr), .tx_done(tx_done),
    .underrun(fifo_underrun), .tun(tun), .tok(tok),
    .irq_ok(irq_ok), .irq_err(irq_err));

  txd_hold_gen #(.CNT_W(CNT_W), .LONG_LIM(LONG_LIM)) u_hold (
    .cnt(byte_cnt), .own(own), .hold(hold_next));

  always_comb begin
    flags.tok  = tok;
    flags.tun  = tun;
    flags.own  = own;
    host_rdata = {flags, byte_cnt};
  end
endmodule

// File: rtl/txd_status_chk.sv
module txd_status_chk #(
  parameter int CNT_W    = 13,
  parameter int LONG_LIM = 1792
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             host_wr,
  input logic             dma_done,
  input logic             own,
  input logic [CNT_W-1:0] byte_cnt,
  input logic             hold_next,
  input logic             tun,
  input logic             tok,
  input logic             irq_ok,
  input logic             irq_err
);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LONG_LIM);

  a_r2_wr_clears_own: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_wr |=> !own);
  a_r4_dma_sets_own: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dma_done && !host_wr) |=> own);
  a_r8_wr_clears_flags: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_wr |=> (!tun && !tok));
  a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_next |-> (!own && byte_cnt > LIM_V));
  a_r5_ok_rise_irq: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(tok) |-> irq_ok);
  a_r6_err_rise_irq: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(tun) |-> irq_err);
  a_r11_ok_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_ok |=> !irq_ok);
  a_r11_irq_mutex: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({irq_ok, irq_err}));
endmodule

bind txd_status_reg txd_status_chk #(.CNT_W(CNT_W), .LONG_LIM(LONG_LIM)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .host_wr(host_wr), .dma_done(dma_done),
  .own(own), .byte_cnt(byte_cnt), .hold_next(hold_next), .tun(tun), .tok(tok),
  .irq_ok(irq_ok), .irq_err(irq_err));

// File: tb/tb_txd_status_reg.sv
module tb_txd_status_reg;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 1792;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, dma_done, tx_done, fifo_underrun;
  logic [15:0] host_wdata, host_rdata;
  logic        own, hold_next, irq_ok, irq_err;
  logic [12:0] byte_cnt;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txd_status_reg dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .dma_done(dma_done), .tx_done(tx_done),
    .fifo_underrun(fifo_underrun), .own(own), .byte_cnt(byte_cnt),
    .hold_next(hold_next), .irq_ok(irq_ok), .irq_err(irq_err));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive for one clock and return at the next falling edge, where the
  // registered outputs of that edge are sampled.
  task automatic step(input logic w, input logic [15:0] d, input logic dm,
                      input logic td, input logic un);
    host_wr = w; host_wdata = d; dma_done = dm; tx_done = td; fifo_underrun = un;
    @(negedge clk);
    host_wr = 0; dma_done = 0; tx_done = 0; fifo_underrun = 0;
  endtask

  function automatic logic [15:0] word(input logic tk, input logic tn,
                                       input logic ow, input logic [12:0] c);
    return {tk, tn, ow, c};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    host_wr = 0; host_wdata = '0; dma_done = 0; tx_done = 0; fifo_underrun = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 word", host_rdata, word(0, 0, 1, 13'd0));
    check("R1 irq/hold", {irq_ok, irq_err, hold_next}, 3'b000);

    // R2 / R9 / R4 sweep across the count range
    for (int c = 0; c < 8192; c += 37) begin
      step(1, 16'(c), 0, 0, 0);
      check("R2 load", host_rdata, word(0, 0, 0, 13'(c)));
      check("R9 hold busy", hold_next, (c > LIM));
      step(0, 16'h0, 1, 0, 0);
      check("R4 own set", own, 1'b1);
      check("R9 hold released", hold_next, 1'b0);
    end
    for (int c = LIM - 3; c <= LIM + 3; c++) begin
      step(1, 16'(c), 0, 0, 0);
      check("R9 boundary", hold_next, (c > LIM));
      step(0, 16'h0, 1, 0, 0);
    end

    // R3 upper write bits ignored
    step(1, 16'hE000 | 16'd100, 0, 0, 0);
    check("R3 ignore hi bits", host_rdata, word(0, 0, 0, 13'd100));

    // R5 success path and R11 repeat
    step(0, 16'h0, 0, 1, 0);
    check("R5 tok set", host_rdata[15:14], 2'b10);
    check("R5 irq_ok pulse", {irq_ok, irq_err}, 2'b10);
    step(0, 16'h0, 0, 0, 0);
    check("R5 irq_ok single", irq_ok, 1'b0);
    step(0, 16'h0, 0, 1, 0);
    check("R11 no repeat irq", {irq_ok, irq_err}, 2'b00);

    // R8 write clears tok
    step(1, 16'd1800, 0, 0, 0);
    check("R8 clear after ok", host_rdata, word(0, 0, 0, 13'd1800));

    // R6 underrun then completion
    step(0, 16'h0, 0, 0, 1);
    check("R6 tun set", host_rdata[15:14], 2'b01);
    check("R6 irq_err pulse", {irq_ok, irq_err}, 2'b01);
    step(0, 16'h0, 0, 1, 0);
    check("R6 tok stays 0", host_rdata[15:14], 2'b01);
    check("R6 no irq after", {irq_ok, irq_err}, 2'b00);
    check("R9 hold still", hold_next, 1'b1);

    // R8 write clears tun
    step(1, 16'd64, 0, 0, 0);
    check("R8 clear after err", host_rdata, word(0, 0, 0, 13'd64));

    // R7 underrun and completion together
    step(0, 16'h0, 0, 1, 1);
    check("R7 flags", host_rdata[15:14], 2'b01);
    check("R7 irq", {irq_ok, irq_err}, 2'b01);

    // R10 write vs DMA done in one cycle
    step(0, 16'h0, 1, 0, 0);
    step(1, 16'd2000, 1, 0, 0);
    check("R10 write wins", host_rdata, word(0, 0, 0, 13'd2000));
    check("R10 hold", hold_next, 1'b1);

    // R1 reset again mid-activity
    rst_n = 0;
    @(negedge clk);
    check("R1 async reset", host_rdata, word(0, 0, 1, 13'd0));
    rst_n = 1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule